// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex, clock-synchronous byte shifter for a microcontroller core. One pin carries data in either direction and a second pin supplies the shift clock to the external device. Only one transfer runs at a time. A write to the data buffer sends the written byte out. When no write is pending, a receive begins as soon as receive-enable is high and the receive-done flag is clear. The block then clocks eight bits in and places them in the buffer.

Each shift-clock period is a fixed number of system clocks (twelve by default). Most of the period is low and a short part is high. Outgoing data changes at the start of each period, so it is stable for the whole low phase before the rising edge. Incoming data is sampled on that same rising edge. When a frame ends, the block raises a done flag for that direction. The flag stays set until software clears it.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the clock pin is high, the data pin is released (enable 0), both done flags are 0 and the receive buffer reads 0x00.
- R2: A buffer write while idle starts a transmit. The data pin enable is 1 for exactly 8×DIV_RATIO clocks, starting the clock after the write.
- R3: The transmit sends the 8 written bits least significant bit first. Each bit is stable on the data pin at the rising edge of the shift clock that marks it.
- R4: Each shift-clock period is DIV_RATIO clocks: low for DIV_RATIO−HIGH_TICKS clocks (10 by default), then high for HIGH_TICKS clocks (2 by default). A frame has exactly 8 rising edges.
- R5: The transmit-done flag becomes 1 exactly 8×DIV_RATIO clocks after the write edge and stays 1 until cleared.
- R6: A receive starts only when receive-enable is 1, the receive-done flag is 0 and no write is present. The data pin stays released for the whole receive.
- R7: A receive samples the input pin on each of the 8 rising edges, least significant bit first. Exactly 8×DIV_RATIO clocks after the start edge, the buffer holds the byte and the receive-done flag is 1.
- R8: A buffer write during a transfer is ignored. The frame in progress goes out unchanged.
- R9: If a write and the receive conditions occur in the same idle cycle, the write wins and a transmit starts.
- R10: A clear pulse on either flag input clears that flag on the next clock.
- R11: While the receive-done flag is 1, no receive starts even with receive-enable held at 1. The clock pin stays high and the buffer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_wr | input | 1 | Write strobe for the data buffer; starts a transmit |
| buf_wdata | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| ti_clr | input | 1 | Clears the transmit-done flag |
| ri_clr | input | 1 | Clears the receive-done flag |
| sd_in | input | 1 | Data pin input value |
| sd_out | output | 1 | Data pin output value |
| sd_oe | output | 1 | Data pin output enable (0 = released) |
| sclk_out | output | 1 | Shift clock pin |
| rx_data | output | 8 | Receive buffer |
| ti_flag | output | 1 | Transmit-done flag |
| ri_flag | output | 1 | Receive-done flag |

## Verification
The bench uses the default parameters: a ratio of twelve, a two-clock high phase and eight-bit frames. With these values the 10/2 clock shape, the 96-clock frame length and the exact cycle of each flag are fixed numbers that the bench can count. It also places a mid-frame write and a collision between a write and a receive start at known phase positions. A table of byte pairs drives alternating transmit and receive frames, with patterns that make a wrong bit order or a lost bit visible.

// File: rtl/ssp_pkg.sv
// Shared types for the synchronous shift-register serial port.
// Assumes nothing beyond standard SystemVerilog packages.
package ssp_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_TX   = 2'd1,
        S_RX   = 2'd2
    } ssp_state_t;
endpackage

// File: rtl/ssp_phase_timer.sv
// Phase and bit counter that shapes the shift clock.
// Each bit period has DIV_RATIO clocks: low first, then HIGH_TICKS clocks high.
// Assumes run is 0 for at least the cycle before a frame begins, so the counters start at zero.
module ssp_phase_timer #(
    parameter int DIV_RATIO  = 12,
    parameter int HIGH_TICKS = 2,
    parameter int FRAME_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic rise_ev,
    output logic bit_end,
    output logic last_bit,
    output logic sclk_hi
);
    localparam int LOW_TICKS = DIV_RATIO - HIGH_TICKS;
    localparam int PH_W      = $clog2(DIV_RATIO);
    localparam int BC_W      = $clog2(FRAME_BITS);
    localparam logic [PH_W-1:0] PH_RISE = PH_W'(LOW_TICKS - 1);
    localparam logic [PH_W-1:0] PH_LOW  = PH_W'(LOW_TICKS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_RATIO - 1);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(FRAME_BITS - 1);

    logic [PH_W-1:0] phase_q;
    logic [BC_W-1:0] bitcnt_q;
    logic            hi_q;

    assign rise_ev  = run && (phase_q == PH_RISE);
    assign bit_end  = run && (phase_q == PH_LAST);
    assign last_bit = (bitcnt_q == BC_LAST);
    assign sclk_hi  = hi_q;

    // Advance the phase within a bit and the bit index within a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q  <= '0;
            bitcnt_q <= '0;
        end else if (phase_q == PH_LAST) begin
            phase_q  <= '0;
            bitcnt_q <= last_bit ? '0 : bitcnt_q + 1'b1;
        end else begin
            phase_q  <= phase_q + 1'b1;
        end
    end

    // Register the high phase of the shift clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
        end else begin
            hi_q <= run && ((phase_q == PH_RISE) ||
                            ((phase_q >= PH_LOW) && (phase_q != PH_LAST)));
        end
    end

    AST_HIGH_STARTS_AT_LOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_q) |-> (phase_q == PH_LOW)); // R4
endmodule

// File: rtl/ssp_shifter.sv
// Shift register shared by transmit and receive.
// Load takes a parallel byte. A transmit shift moves right with zero fill.
// A receive shift moves right and inserts the pin value at the top, so the first bit ends in bit 0.
// Assumes at most one of the three controls is active in a cycle.
module ssp_shifter #(
    parameter int FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_val,
    input  logic                  shift_out,
    input  logic                  shift_in,
    input  logic                  din,
    output logic [FRAME_BITS-1:0] q
);
    logic [FRAME_BITS-1:0] sr_q;
    assign q = sr_q;

    // Load, shift toward bit 0, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_val;
        end else if (shift_out) begin
            sr_q <= {1'b0, sr_q[FRAME_BITS-1:1]};
        end else if (shift_in) begin
            sr_q <= {din, sr_q[FRAME_BITS-1:1]};
        end
    end

    AST_SHIFT_CTRL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load, shift_out, shift_in})); // R2
endmodule

// File: rtl/sync_shift_port.sv
// Half-duplex synchronous serial port, eight bits per frame, LSB first.
// A buffer write starts a transmit. Receive-enable with a clear receive flag starts a receive.
// Assumes software clears the done flags. Writes during a transfer are dropped.
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int DIV_RATIO  = 12,
    parameter int HIGH_TICKS = 2,
    parameter int FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  buf_wr,
    input  logic [FRAME_BITS-1:0] buf_wdata,
    input  logic                  rx_en,
    input  logic                  ti_clr,
    input  logic                  ri_clr,
    input  logic                  sd_in,
    output logic                  sd_out,
    output logic                  sd_oe,
    output logic                  sclk_out,
    output logic [FRAME_BITS-1:0] rx_data,
    output logic                  ti_flag,
    output logic                  ri_flag
);
    ssp_state_t            state_q;
    logic                  rise_ev, bit_end, last_bit, sclk_hi;
    logic                  start_tx, start_rx, frame_end;
    logic [FRAME_BITS-1:0] sr;
    logic [FRAME_BITS-1:0] rbuf_q;
    logic                  ti_q, ri_q;

    assign start_tx  = (state_q == S_IDLE) && buf_wr;
    assign start_rx  = (state_q == S_IDLE) && !buf_wr && rx_en && !ri_q;
    assign frame_end = bit_end && last_bit;

    ssp_phase_timer #(
        .DIV_RATIO (DIV_RATIO),
        .HIGH_TICKS(HIGH_TICKS),
        .FRAME_BITS(FRAME_BITS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q != S_IDLE),
        .rise_ev (rise_ev),
        .bit_end (bit_end),
        .last_bit(last_bit),
        .sclk_hi (sclk_hi)
    );

    ssp_shifter #(
        .FRAME_BITS(FRAME_BITS)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_tx),
        .load_val (buf_wdata),
        .shift_out((state_q == S_TX) && bit_end && !last_bit),
        .shift_in ((state_q == S_RX) && rise_ev),
        .din      (sd_in),
        .q        (sr)
    );

    // Frame sequencing: idle, transmit or receive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            case (state_q)
                S_IDLE:  state_q <= start_tx ? S_TX : (start_rx ? S_RX : S_IDLE);
                S_TX,
                S_RX:    if (frame_end) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Capture the received byte at the end of a receive frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf_q <= '0;
        end else if ((state_q == S_RX) && frame_end) begin
            rbuf_q <= sr;
        end
    end

    // Done flags: a set from a finished frame takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ti_q <= 1'b0;
            ri_q <= 1'b0;
        end else begin
            if ((state_q == S_TX) && frame_end) ti_q <= 1'b1;
            else if (ti_clr)                    ti_q <= 1'b0;
            if ((state_q == S_RX) && frame_end) ri_q <= 1'b1;
            else if (ri_clr)                    ri_q <= 1'b0;
        end
    end

    assign sd_out   = sr[0];
    assign sd_oe    = (state_q == S_TX);
    assign sclk_out = (state_q == S_IDLE) || sclk_hi;
    assign rx_data  = rbuf_q;
    assign ti_flag  = ti_q;
    assign ri_flag  = ri_q;

    AST_OE_DROP_SETS_TI: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_oe) |-> ti_flag); // R5
    AST_TX_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_oe && $rose(sclk_out)) |-> $stable(sd_out)); // R3
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && buf_wr) |=> sd_oe); // R9
    AST_BUSY_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != S_IDLE) && !frame_end) |=> (state_q == $past(state_q))); // R8
    AST_RI_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && !buf_wr && ri_flag) |=> (state_q == S_IDLE)); // R11
    AST_RX_END_SETS_RI: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_RX) && frame_end) |=> ri_flag); // R7
    AST_RX_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RX) |-> !sd_oe); // R6
endmodule

// File: tb/test_sync_shift_port.sv
module test_sync_shift_port;
    localparam int DIV   = 12;
    localparam int NB    = 8;
    localparam int FRAME = DIV * NB;
    localparam logic [15:0] VEC [0:5] = '{16'hA5_3C, 16'h01_80, 16'hFF_00,
                                          16'h80_01, 16'h5A_C3, 16'h00_FF};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic buf_wr = 1'b0, rx_en = 1'b0, ti_clr = 1'b0, ri_clr = 1'b0, sd_in = 1'b0;
    logic [7:0] buf_wdata = 8'h00;
    logic sd_out, sd_oe, sclk_out, ti_flag, ri_flag;
    logic [7:0] rx_data;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    sync_shift_port #(.DIV_RATIO(DIV), .HIGH_TICKS(2), .FRAME_BITS(NB)) i_sync_shift_port (
        .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .rx_en(rx_en), .ti_clr(ti_clr), .ri_clr(ri_clr), .sd_in(sd_in),
        .sd_out(sd_out), .sd_oe(sd_oe), .sclk_out(sclk_out), .rx_data(rx_data),
        .ti_flag(ti_flag), .ri_flag(ri_flag));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Transmit one byte; optionally write another byte mid-frame.
    task automatic run_tx(input logic [7:0] b, input bit inject);
        logic [7:0] got = 8'h00;
        int nrise = 0, lows = 0, oe_low = 0;
        logic prev = 1'b0;
        @(negedge clk) ti_clr = 1'b1;
        @(negedge clk) ti_clr = 1'b0;
        chk("R10 ti cleared", {31'd0, ti_flag}, 32'd0);
        buf_wr = 1'b1; buf_wdata = b;
        @(negedge clk) buf_wr = 1'b0;
        for (int k = 1; k <= FRAME; k++) begin
            if (sclk_out && !prev) begin
                if (nrise < 8) got[nrise] = sd_out;
                nrise++;
            end
            if (!sclk_out) lows++;
            if (!sd_oe) oe_low++;
            if (k == FRAME) chk("R5 ti low before end", {31'd0, ti_flag}, 32'd0);
            if (inject && k == 20) begin buf_wr = 1'b1; buf_wdata = ~b; end
            if (inject && k == 21) buf_wr = 1'b0;
            prev = sclk_out;
            @(negedge clk);
        end
        chk(inject ? "R8 byte kept under busy write" : "R3 tx bits LSB first", {24'd0, got}, {24'd0, b});
        chk("R4 rising edges per frame", nrise, 8);
        chk("R4 low clocks per frame", lows, 8 * (DIV - 2));
        chk("R2 oe high whole frame", oe_low, 0);
        chk("R5 ti set at frame end", {31'd0, ti_flag}, 32'd1);
        chk("R2 oe released after frame", {31'd0, sd_oe}, 32'd0);
    endtask

    // Receive one byte driven by the bench, then check that a set flag blocks a new receive.
    task automatic run_rx(input logic [7:0] b);
        int idx = 0, oe_hi = 0, clk_low = 0;
        logic prev = 1'b0;
        @(negedge clk) ri_clr = 1'b1;
        @(negedge clk) ri_clr = 1'b0;
        chk("R10 ri cleared", {31'd0, ri_flag}, 32'd0);
        sd_in = b[0]; rx_en = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= FRAME; k++) begin
            if (sclk_out && !prev) begin
                idx++;
                if (idx < 8) sd_in = b[idx[2:0]];
            end
            if (sd_oe) oe_hi++;
            if (k == FRAME) chk("R7 ri low before end", {31'd0, ri_flag}, 32'd0);
            prev = sclk_out;
            @(negedge clk);
        end
        chk("R7 rx byte", {24'd0, rx_data}, {24'd0, b});
        chk("R7 ri set at frame end", {31'd0, ri_flag}, 32'd1);
        chk("R6 pin released in rx", oe_hi, 0);
        sd_in = ~sd_in;
        for (int k = 0; k < 30; k++) begin
            if (!sclk_out) clk_low++;
            @(negedge clk);
        end
        chk("R11 no rx while ri set", clk_low, 0);
        chk("R11 buffer held", {24'd0, rx_data}, {24'd0, b});
        rx_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sclk idle high", {31'd0, sclk_out}, 32'd1);
        chk("R1 pin released", {31'd0, sd_oe}, 32'd0);
        chk("R1 ti reset", {31'd0, ti_flag}, 32'd0);
        chk("R1 ri reset", {31'd0, ri_flag}, 32'd0);
        chk("R1 buffer reset", {24'd0, rx_data}, 32'd0);

        for (int i = 0; i < 6; i++) begin
            run_tx(VEC[i][15:8], 1'b0);
            run_rx(VEC[i][7:0]);
        end

        run_tx(8'hC6, 1'b1);

        // R9: write and receive request in the same idle cycle
        @(negedge clk) ri_clr = 1'b1;
        @(negedge clk) ri_clr = 1'b0; ti_clr = 1'b1;
        @(negedge clk) ti_clr = 1'b0; rx_en = 1'b1; buf_wr = 1'b1; buf_wdata = 8'h96;
        @(negedge clk) buf_wr = 1'b0; rx_en = 1'b0;
        chk("R9 write wins over rx", {31'd0, sd_oe}, 32'd1);
        repeat (FRAME + 2) @(negedge clk);
        chk("R9 transmit completed", {31'd0, ti_flag}, 32'd1);
        chk("R9 no receive happened", {31'd0, ri_flag}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule